// File: doc/BRIEF.md
# Tagged Two-Bit Branch Predictor

This block gives a pipelined fetch stage a taken or not-taken guess for each conditional branch it fetches. It holds a small direct-mapped table of recently resolved branches. Each entry keeps a valid bit, an address tag and a 2-bit saturating confidence counter. A fetch presents the branch address and its signed relative displacement, and the block answers in the same cycle. When the address hits a valid entry with a matching tag, the counter decides the guess. When it misses, a static rule applies: a backward branch (negative displacement) is guessed taken and a forward branch is guessed not taken.

When a branch executes, the pipeline reports its address and real outcome on the resolve port. A hit moves the counter one step toward the outcome and stops at the ends. A miss claims the entry for this branch, evicts whatever was there, and starts the counter on the weak side of the outcome. A hit flag goes out with every guess, so the fetch logic or a bench can tell a learned guess from a static one.

Top module: `tagged_2bit_bpred`

## Requirements
- R1: After a synchronous reset every entry is invalid, so every lookup reports `pred_hit` = 0 until a branch has been resolved into its entry.
- R2: On a miss, `pred_taken` equals the sign bit of `lk_disp`: 1 (taken) for a negative displacement, 0 (not taken) for zero or a positive one.
- R3: A resolve that misses allocates the entry. From the next cycle a lookup of that address hits, with counter 2 (taken) if the outcome was taken and 1 (not taken) otherwise.
- R4: A taken resolve that hits raises the counter by one and holds it at 3. After reaching 3, one further taken outcome followed by a single not-taken outcome still leaves a taken guess.
- R5: A not-taken resolve that hits lowers the counter by one and holds it at 0. After reaching 0, one further not-taken outcome followed by a single taken outcome still leaves a not-taken guess.
- R6: On a hit the guess is taken for counter 2 or 3 and not taken for 0 or 1, whatever the displacement.
- R7: The entry index is address bits [5:2] and the tag is bits [31:6]. An address with the same index and a different tag misses. Resolving such an address replaces the previous occupant, which then misses.
- R8: A resolve takes effect on the clock edge. A lookup of the same entry in the same cycle returns the guess from the state before that resolve.
- R9: Address bits [1:0] are not used for the index or the tag, so addresses that differ only in those bits share one entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all valid bits |
| lk_addr | input | 32 | Address of the branch being fetched |
| lk_disp | input | 16 | Signed relative displacement of that branch |
| pred_taken | output | 1 | Guess: 1 taken, 0 not taken |
| pred_hit | output | 1 | 1 when the guess came from a table entry |
| rs_valid | input | 1 | A resolved branch is presented this cycle |
| rs_addr | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Real outcome of the resolved branch |

## Verification
A wrong counter shows up as a flipped guess only when it crosses the 1/2 boundary. So the bench steps each counter up to both ends and then back by one step, which turns an off-by-one saturation into a visible error within two resolves. A corrupted tag or valid bit shows up at once on `pred_hit`, one cycle after the resolve that wrote the entry. A slice error in the index or tag shows up as a wrong hit or miss for aliased or offset addresses. A scoreboard model of the table runs a long pseudo-random mix of lookups and resolves over colliding addresses, so mistakes in eviction or ordering surface within a few cycles of the access that causes them.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  typedef enum logic [1:0] {
    CNT_SNT = 2'd0,
    CNT_WNT = 2'd1,
    CNT_WT  = 2'd2,
    CNT_ST  = 2'd3
  } ctr_t;
endpackage

// File: rtl/bp_static.sv
module bp_static #(
  parameter int DISP_W = 16
) (
  input  logic              disp_sign,
  output logic              guess
);
  // Negative displacement means a backward branch, which is guessed taken.
  assign guess = disp_sign;
endmodule

// File: rtl/bp_ctr_update.sv
module bp_ctr_update
  import bpred_pkg::*;
(
  input  ctr_t cur,
  input  logic hit,
  input  logic taken,
  output ctr_t nxt
);
  always_comb begin
    if (!hit)
      nxt = taken ? CNT_WT : CNT_WNT;
    else if (taken)
      nxt = (cur == CNT_ST) ? CNT_ST : ctr_t'(cur + 2'd1);
    else
      nxt = (cur == CNT_SNT) ? CNT_SNT : ctr_t'(cur - 2'd1);
  end
endmodule

// File: rtl/bp_table.sv
module bp_table
  import bpred_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 26,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] ra_idx,
  output logic             ra_valid,
  output logic [TAG_W-1:0] ra_tag,
  output ctr_t             ra_cnt,
  input  logic [IDX_W-1:0] rb_idx,
  output logic             rb_valid,
  output logic [TAG_W-1:0] rb_tag,
  output ctr_t             rb_cnt,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [TAG_W-1:0] w_tag,
  input  ctr_t             w_cnt
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_mem [ENTRIES];
  ctr_t               cnt_mem [ENTRIES];

  // Valid bits sit in flops so reset can clear them in one cycle.
  always_ff @(posedge clk) begin
    if (rst)
      valid_q <= '0;
    else if (we)
      valid_q[w_idx] <= 1'b1;
  end

  // Tag and counter storage has no reset, so it can map to distributed RAM.
  always_ff @(posedge clk) begin
    if (we && !rst) begin
      tag_mem[w_idx] <= w_tag;
      cnt_mem[w_idx] <= w_cnt;
    end
  end

  assign ra_valid = valid_q[ra_idx];
  assign ra_tag   = tag_mem[ra_idx];
  assign ra_cnt   = cnt_mem[ra_idx];
  assign rb_valid = valid_q[rb_idx];
  assign rb_tag   = tag_mem[rb_idx];
  assign rb_cnt   = cnt_mem[rb_idx];

  // R3
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (valid_q[$past(w_idx)] && tag_mem[$past(w_idx)] == $past(w_tag)
            && cnt_mem[$past(w_idx)] == $past(w_cnt)));
endmodule

// File: rtl/tagged_2bit_bpred.sv
module tagged_2bit_bpred
  import bpred_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DISP_W   = 16,
  parameter int ENTRIES  = 16,
  parameter int WORD_OFF = 2,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int TAG_W   = ADDR_W - WORD_OFF - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [DISP_W-1:0] lk_disp,
  output logic              pred_taken,
  output logic              pred_hit,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_addr,
  input  logic              rs_taken
);
  logic [IDX_W-1:0] lk_idx, rs_idx;
  logic [TAG_W-1:0] lk_tag, rs_tag;
  logic             lk_v, rs_v;
  logic [TAG_W-1:0] lk_stag, rs_stag;
  ctr_t             lk_cnt, rs_cnt, upd_cnt;
  logic             rs_hit, static_guess;
  logic             unused_ok;

  assign lk_idx = lk_addr[WORD_OFF +: IDX_W];
  assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
  assign rs_idx = rs_addr[WORD_OFF +: IDX_W];
  assign rs_tag = rs_addr[ADDR_W-1 -: TAG_W];
  assign unused_ok = ^{lk_disp[DISP_W-2:0], lk_addr[WORD_OFF-1:0], rs_addr[WORD_OFF-1:0]};

  bp_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_table (
    .clk(clk), .rst(rst),
    .ra_idx(lk_idx), .ra_valid(lk_v), .ra_tag(lk_stag), .ra_cnt(lk_cnt),
    .rb_idx(rs_idx), .rb_valid(rs_v), .rb_tag(rs_stag), .rb_cnt(rs_cnt),
    .we(rs_valid), .w_idx(rs_idx), .w_tag(rs_tag), .w_cnt(upd_cnt)
  );

  assign rs_hit = rs_v && (rs_stag == rs_tag);

  bp_ctr_update u_upd (
    .cur(rs_cnt), .hit(rs_hit), .taken(rs_taken), .nxt(upd_cnt)
  );

  bp_static #(.DISP_W(DISP_W)) u_static (
    .disp_sign(lk_disp[DISP_W-1]), .guess(static_guess)
  );

  always_comb begin
    pred_hit   = lk_v && (lk_stag == lk_tag);
    pred_taken = pred_hit ? lk_cnt[1] : static_guess;
  end

  // R1
  rst_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pred_hit);
  // R2
  static_rule_chk: assert property (@(posedge clk) disable iff (rst)
    !pred_hit |-> (pred_taken == lk_disp[DISP_W-1]));
  // R4
  sat_up_chk: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_hit && rs_taken) |-> (upd_cnt >= rs_cnt && upd_cnt != CNT_SNT));
  // R5
  sat_dn_chk: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_hit && !rs_taken) |-> (upd_cnt <= rs_cnt && upd_cnt != CNT_ST));
endmodule

// File: tb/tb_tagged_2bit_bpred.sv
module tb_tagged_2bit_bpred;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_addr = '0;
  logic [15:0] lk_disp = '0;
  logic        pred_taken, pred_hit;
  logic        rs_valid = 1'b0;
  logic [31:0] rs_addr = '0;
  logic        rs_taken = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  exp_t;
    logic  exp_h;
    string req;
  } item_t;
  item_t q[$];

  // Reference model of the table state, built from the requirements
  logic        m_v   [16];
  logic [25:0] m_tag [16];
  int          m_cnt [16];

  always #10 clk = ~clk;

  tagged_2bit_bpred dut (
    .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_disp(lk_disp),
    .pred_taken(pred_taken), .pred_hit(pred_hit),
    .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_taken(rs_taken)
  );

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
  endtask

  // One cycle: lookup always checked; optional resolve applied at the next edge.
  task automatic step(input logic [31:0] la, input logic [15:0] ld,
                      input logic rv, input logic [31:0] ra, input logic rt,
                      input string req);
    item_t it;
    int li, ri;
    @(negedge clk);
    lk_addr = la; lk_disp = ld;
    rs_valid = rv; rs_addr = ra; rs_taken = rt;
    li = int'(la[5:2]);
    it.exp_h = m_v[li] && (m_tag[li] == la[31:6]);
    it.exp_t = it.exp_h ? (m_cnt[li] >= 2) : ld[15];
    it.req = req;
    q.push_back(it);
    if (rv) begin
      ri = int'(ra[5:2]);
      if (m_v[ri] && m_tag[ri] == ra[31:6]) begin
        if (rt) m_cnt[ri] = (m_cnt[ri] == 3) ? 3 : m_cnt[ri] + 1;
        else    m_cnt[ri] = (m_cnt[ri] == 0) ? 0 : m_cnt[ri] - 1;
      end else begin
        m_v[ri] = 1'b1; m_tag[ri] = ra[31:6]; m_cnt[ri] = rt ? 2 : 1;
      end
    end
  endtask

  task automatic look(input logic [31:0] la, input logic [15:0] ld, input string req);
    step(la, ld, 1'b0, 32'h0, 1'b0, req);
  endtask

  task automatic resolve(input logic [31:0] ra, input logic rt, input string req);
    step(ra, 16'h0001, 1'b1, ra, rt, req);
  endtask

  // Monitor: pops expectations mid-cycle, away from the clock edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #5;
      while (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (pred_taken !== it.exp_t || pred_hit !== it.exp_h) begin
          errors++;
          $display("FAIL %s: taken/hit actual %b/%b expected %b/%b",
                   it.req, pred_taken, pred_hit, it.exp_t, it.exp_h);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [31:0] A  = 32'h0000_1040; // idx 0
  localparam logic [31:0] B  = 32'h0000_2044; // idx 1
  localparam logic [31:0] C  = 32'h0000_3048; // idx 2
  localparam logic [31:0] A2 = 32'h0000_5040; // idx 0, other tag

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: nothing hits after reset
    look(A, 16'h0010, "R1");
    look(B, 16'hFFF0, "R1");
    // R2: static rule on miss
    look(C, 16'h8000, "R2");
    look(C, 16'h7FFF, "R2");
    look(C, 16'h0000, "R2");
    // R3: allocation, taken -> 2, not taken -> 1
    resolve(A, 1'b1, "R3");
    look(A, 16'h0010, "R3");
    resolve(B, 1'b0, "R3");
    look(B, 16'hFFF0, "R3");
    // R4: climb to 3, one extra taken, then one not-taken stays taken
    resolve(A, 1'b1, "R4");
    resolve(A, 1'b1, "R4");
    resolve(A, 1'b0, "R4");
    look(A, 16'h0000, "R4");
    resolve(A, 1'b0, "R4");
    look(A, 16'h0000, "R4");
    // R5: drop B to 0, one extra, then one taken stays not taken
    resolve(B, 1'b0, "R5");
    resolve(B, 1'b0, "R5");
    resolve(B, 1'b1, "R5");
    look(B, 16'h8000, "R5");
    // R6: hit ignores displacement
    look(B, 16'hFFFF, "R6");
    look(A, 16'h0001, "R6");
    // R7: aliasing tag misses and evicts
    look(A2, 16'h0004, "R7");
    resolve(A2, 1'b1, "R7");
    look(A2, 16'h0004, "R7");
    look(A, 16'h0004, "R7");
    // R8: same-cycle resolve does not change this cycle's guess
    step(C, 16'h0002, 1'b1, C, 1'b1, "R8");
    look(C, 16'h0002, "R8");
    step(C, 16'h0002, 1'b1, C, 1'b0, "R8");
    step(C, 16'h0002, 1'b1, C, 1'b0, "R8");
    look(C, 16'hFFFE, "R8");
    // R9: low byte bits share an entry
    look(B + 32'd3, 16'h8000, "R9");
    look(A2 + 32'd1, 16'h0000, "R9");
    // R1: reset again clears learned entries
    @(negedge clk); rst = 1'b1; model_reset();
    @(negedge clk); rst = 1'b0;
    look(A2, 16'h0000, "R1");
    look(B, 16'h0000, "R1");
    // R6: pseudo-random mix over colliding addresses
    for (int n = 0; n < 400; n++) begin
      logic [31:0] la, ra;
      la = {24'h0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
      ra = {24'h0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
      step(la, 16'($urandom), 1'($urandom), ra, 1'($urandom), "R6");
    end
    @(negedge clk);
    rs_valid = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule